// File: doc/BRIEF.md
# Timed-Unlock EEPROM Write Controller

This block gives a small CPU byte-wide access to a 64-byte non-volatile store held inside the block. Software reaches it through three registers on a simple write bus: an address register, a data register and a control register. Reads are immediate. The addressed byte lands in the data register, and the CPU is held off for a few cycles while that happens.

Writes are guarded by a two-step unlock. Software first sets an arm bit, and that bit is only accepted in a control write that leaves the write bit at zero. The arm bit then expires on its own after a fixed number of clocks. A write bit that arrives while the block is armed starts a programming cycle. A write bit that arrives at any other time does nothing. The write bit then reads back as one for a parameterised number of cycles that models the cell programming time. When that time ends the byte is committed and the bit clears.

If software touches the address or data register during that time, the block flags the write as failed and does not commit it. A ready interrupt request is held high while no write is busy, as long as both the local enable and the global enable are on.

Top module: `eeprom_unlock_ctrl`

## Requirements
- R1: After reset all control bits read 0, and the stall, failure and interrupt outputs are 0. The address and data registers are 0 and every stored byte is 0.
- R2: Register select codes are: 0 address, 1 data, 2 control. In the control register, bit 0 is read, bit 1 is write/busy, bit 2 is arm and bit 3 is ready-interrupt enable. Any control write loads bit 3. A control write sets arm only when its bit 1 is 0; writing bits 2 and 1 together leaves arm at 0.
- R3: Once set, arm reads 1 for exactly ARM_CYCLES (4) cycles and then clears without any software action.
- R4: A control write with bit 1 set starts a write only if arm is 1 at that clock edge. The last cycle of the arm window still counts. Outside the window the write bit has no effect: busy stays 0 and the stored byte is unchanged. Starting a write clears arm.
- R5: After a write starts, the busy bit reads 1 for exactly WR_CYCLES cycles. It then clears, and the data byte is stored at the address.
- R6: Starting a write raises the CPU stall output for exactly 2 cycles.
- R7: A control write with bit 0 set while no write is busy loads the addressed byte into the data register at that edge. It raises the CPU stall for exactly 4 cycles. Bit 0 reads 1 only during that stall and then clears by itself.
- R8: The ready interrupt request equals (not busy) AND ready-interrupt enable AND the global enable, on every cycle.
- R9: A write to the address or data register while busy sets the failure output. That write is then not stored. The failure output stays set until the next write starts, which clears it.
- R10: A read request made while busy is ignored, and the data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busSel | input | 2 | Register select: 0 address, 1 data, 2 control |
| busWdata | input | 8 | Register write data |
| globalIntEn | input | 1 | CPU global interrupt enable |
| addrOut | output | 6 | Address register contents |
| dataOut | output | 8 | Data register contents |
| ctrlOut | output | 4 | Control register: {irq enable, arm, busy, read} |
| cpuStall | output | 1 | Holds the CPU during read and write start |
| readyIrq | output | 1 | Ready interrupt request |
| writeFail | output | 1 | Last write was corrupted and not stored |

## Verification
Several properties are checked on every cycle by assertions:
- the arm window never runs longer than its length;
- a rejected write bit cannot arm the block;
- busy rises only straight after an armed cycle, with the stall raised;
- the interrupt is masked while busy;
- a read request during busy leaves the data register alone;
- a register write during busy always raises the failure flag.

Other behaviours only the bench scenarios can show:
- that the byte really reaches the array, or is withheld after corruption;
- the exact busy and stall lengths;
- the edge-of-window acceptance;
- the value returned by a read.

// File: rtl/eeprom_unlock_pkg.sv
package eeprom_unlock_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2
  } regSel_e;

  localparam int CTRL_RD  = 0;
  localparam int CTRL_WR  = 1;
  localparam int CTRL_ARM = 2;
  localparam int CTRL_IE  = 3;

  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic readMem;
    logic commitMem;
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_unlock_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ARM_CYCLES = 4,
  parameter int WR_CYCLES  = 40,
  parameter int RD_STALL   = 4,
  parameter int WR_STALL   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [1:0]        busSel,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              globalIntEn,
  output dpStrobe_t         strobes,
  output logic              armed,
  output logic              busy,
  output logic              readActive,
  output logic              readyIe,
  output logic              cpuStall,
  output logic              writeFail,
  output logic              readyIrq
);

  localparam int ARM_W   = $clog2(ARM_CYCLES + 1);
  localparam int LAT_W   = $clog2(WR_CYCLES + 1);
  localparam int STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int STALL_W = $clog2(STALL_MAX + 1);

  logic [ARM_W-1:0]   armCnt;
  logic [LAT_W-1:0]   latCnt;
  logic [STALL_W-1:0] stallCnt;
  logic               failReg;
  logic               rdFlag;
  logic               ieReg;

  logic ctrlWr, regWr, startWrite, armRequest, startRead, finishing;

  always_comb begin
    ctrlWr     = busWe && (busSel == SEL_CTRL);
    regWr      = busWe && ((busSel == SEL_ADDR) || (busSel == SEL_DATA));
    startWrite = ctrlWr && busWdata[CTRL_WR] && (armCnt != '0) && (latCnt == '0);
    armRequest = ctrlWr && busWdata[CTRL_ARM] && !busWdata[CTRL_WR];
    startRead  = ctrlWr && busWdata[CTRL_RD] && (latCnt == '0) && !startWrite;
    finishing  = (latCnt == LAT_W'(1));
  end

  // arm window
  always_ff @(posedge clk) begin
    if (!rstN)                armCnt <= '0;
    else if (startWrite)      armCnt <= '0;
    else if (armRequest)      armCnt <= ARM_W'(ARM_CYCLES);
    else if (armCnt != '0)    armCnt <= armCnt - ARM_W'(1);
  end

  // programming latency
  always_ff @(posedge clk) begin
    if (!rstN)                latCnt <= '0;
    else if (startWrite)      latCnt <= LAT_W'(WR_CYCLES);
    else if (latCnt != '0)    latCnt <= latCnt - LAT_W'(1);
  end

  // corruption tracking
  always_ff @(posedge clk) begin
    if (!rstN)                          failReg <= 1'b0;
    else if (startWrite)                failReg <= 1'b0;
    else if ((latCnt != '0) && regWr)   failReg <= 1'b1;
  end

  // CPU hold-off
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0;
      rdFlag   <= 1'b0;
    end else if (startWrite) begin
      stallCnt <= STALL_W'(WR_STALL);
      rdFlag   <= 1'b0;
    end else if (startRead) begin
      stallCnt <= STALL_W'(RD_STALL);
      rdFlag   <= 1'b1;
    end else if (stallCnt != '0) begin
      stallCnt <= stallCnt - STALL_W'(1);
      if (stallCnt == STALL_W'(1)) rdFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       ieReg <= 1'b0;
    else if (ctrlWr) ieReg <= busWdata[CTRL_IE];
  end

  always_comb begin
    strobes.loadAddr  = busWe && (busSel == SEL_ADDR);
    strobes.loadData  = busWe && (busSel == SEL_DATA);
    strobes.readMem   = startRead;
    strobes.commitMem = finishing && !failReg && !regWr;
    armed      = (armCnt != '0);
    busy       = (latCnt != '0);
    readActive = rdFlag;
    readyIe    = ieReg;
    cpuStall   = (stallCnt != '0);
    writeFail  = failReg;
    readyIrq   = (latCnt == '0) && ieReg && globalIntEn;
  end

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_unlock_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [DATA_W-1:0] busWdata,
  output logic [ADDR_W-1:0] addrReg,
  output logic [DATA_W-1:0] dataReg
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN)                 addrReg <= '0;
    else if (strobes.loadAddr) addrReg <= busWdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 dataReg <= '0;
    else if (strobes.loadData) dataReg <= busWdata;
    else if (strobes.readMem)  dataReg <= memArr[addrReg];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
    end else if (strobes.commitMem) begin
      memArr[addrReg] <= dataReg;
    end
  end

endmodule

// File: rtl/eeprom_unlock_ctrl.sv
module eeprom_unlock_ctrl
  import eeprom_unlock_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int ARM_CYCLES = 4,
  parameter int WR_CYCLES  = 40,
  parameter int RD_STALL   = 4,
  parameter int WR_STALL   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [1:0]        busSel,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              globalIntEn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [3:0]        ctrlOut,
  output logic              cpuStall,
  output logic              readyIrq,
  output logic              writeFail
);

  dpStrobe_t strobes;
  logic armed, busy, readActive, readyIe;

  eeprom_ctrl #(
    .DATA_W(DATA_W), .ARM_CYCLES(ARM_CYCLES), .WR_CYCLES(WR_CYCLES),
    .RD_STALL(RD_STALL), .WR_STALL(WR_STALL)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busSel(busSel),
    .busWdata(busWdata), .globalIntEn(globalIntEn), .strobes(strobes),
    .armed(armed), .busy(busy), .readActive(readActive), .readyIe(readyIe),
    .cpuStall(cpuStall), .writeFail(writeFail), .readyIrq(readyIrq)
  );

  eeprom_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .addrReg(addrOut), .dataReg(dataOut)
  );

  assign ctrlOut = {readyIe, armed, busy, readActive};

endmodule

// File: rtl/eeprom_unlock_ctrl_chk.sv
module eeprom_unlock_ctrl_chk #(
  parameter int DATA_W     = 8,
  parameter int ARM_CYCLES = 4,
  parameter int WR_CYCLES  = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [1:0]        busSel,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] dataOut,
  input logic [3:0]        ctrlOut,
  input logic              cpuStall,
  input logic              readyIrq,
  input logic              writeFail
);

  int armRun;
  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armRun  <= 0;
      busyRun <= 0;
    end else begin
      armRun  <= ctrlOut[2] ? armRun + 1 : 0;
      busyRun <= ctrlOut[1] ? busyRun + 1 : 0;
    end
  end

  p_arm_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    armRun <= ARM_CYCLES);

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= WR_CYCLES);

  p_no_arm_with_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busSel == 2'd2 && busWdata[1] && !ctrlOut[2]) |=> !ctrlOut[2]);

  p_start_needs_arm_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlOut[1]) |-> $past(ctrlOut[2]));

  p_start_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlOut[1]) |-> cpuStall);

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut[1] |-> !readyIrq);

  p_fail_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut[1] && busWe && (busSel == 2'd0 || busSel == 2'd1)) |=> writeFail);

  p_read_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut[1] && busWe && busSel == 2'd2 && busWdata[0]) |=> $stable(dataOut));

endmodule

bind eeprom_unlock_ctrl eeprom_unlock_ctrl_chk #(
  .DATA_W(DATA_W), .ARM_CYCLES(ARM_CYCLES), .WR_CYCLES(WR_CYCLES)
) chk_i (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busSel(busSel),
  .busWdata(busWdata), .dataOut(dataOut), .ctrlOut(ctrlOut),
  .cpuStall(cpuStall), .readyIrq(readyIrq), .writeFail(writeFail)
);

// File: tb/eeprom_unlock_ctrl_tb_top.sv
module eeprom_unlock_ctrl_tb_top;

  localparam int WR_CYC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [1:0] busSel = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic globalIntEn = 1'b0;
  logic [5:0] addrOut;
  logic [7:0] dataOut;
  logic [3:0] ctrlOut;
  logic cpuStall, readyIrq, writeFail;

  always #4 clk = ~clk;

  eeprom_unlock_ctrl #(.WR_CYCLES(WR_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busSel(busSel),
    .busWdata(busWdata), .globalIntEn(globalIntEn), .addrOut(addrOut),
    .dataOut(dataOut), .ctrlOut(ctrlOut), .cpuStall(cpuStall),
    .readyIrq(readyIrq), .writeFail(writeFail)
  );

  typedef struct {
    string tag;
    string what;
    int    sigId;
    int    exp;
    int    act;
  } expItem_t;

  expItem_t scoreQ[$];
  event sampleEv;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  function automatic int readSig(int id, int given);
    case (id)
      0: return int'(ctrlOut);
      1: return int'(cpuStall);
      2: return int'(readyIrq);
      3: return int'(writeFail);
      4: return int'(dataOut);
      5: return int'(addrOut);
      default: return given;
    endcase
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(sampleEv);
      while (scoreQ.size() > 0) begin
        expItem_t it;
        int act;
        it = scoreQ.pop_front();
        act = readSig(it.sigId, it.act);
        nChecks++;
        if (act != it.exp) begin
          nFails++;
          $display("FAIL %s %s: actual %0h expected %0h", it.tag, it.what, act, it.exp);
        end
      end
    end
  end

  task automatic expect_sig(string tag, string what, int id, int exp, int act = 0);
    expItem_t it;
    it.tag = tag; it.what = what; it.sigId = id; it.exp = exp; it.act = act;
    scoreQ.push_back(it);
    ->sampleEv;
    wait (scoreQ.size() == 0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic busWrite(logic [1:0] sel, logic [7:0] val);
    busWe = 1'b1; busSel = sel; busWdata = val;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic waitIdle();
    while (ctrlOut[1]) @(negedge clk);
  endtask

  task automatic doRead(logic [5:0] a);
    busWrite(2'd0, {2'b00, a});
    busWrite(2'd2, 8'h09);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int nBusy, nStall, nRdStall;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_sig("R1", "ctrl", 0, 0);
    expect_sig("R1", "stall", 1, 0);
    expect_sig("R1", "fail", 3, 0);
    expect_sig("R1", "irq", 2, 0);
    expect_sig("R1", "addr", 5, 0);
    expect_sig("R1", "data", 4, 0);

    // R8 interrupt enable
    globalIntEn = 1'b1;
    busWrite(2'd2, 8'h08);
    expect_sig("R8", "irq idle", 2, 1);

    // R2 arm together with write is refused
    busWrite(2'd0, 8'h05);
    busWrite(2'd1, 8'hA5);
    busWrite(2'd2, 8'h0E);
    expect_sig("R2", "ctrl after arm+wr", 0, 8'h8);

    // R3 arm window length
    busWrite(2'd2, 8'h0C);
    expect_sig("R2", "armed", 0, 8'hC);
    idle(3);
    expect_sig("R3", "armed last cycle", 0, 8'hC);
    idle(1);
    expect_sig("R3", "arm expired", 0, 8'h8);

    // R4 write strobe outside window has no effect
    busWrite(2'd2, 8'h0A);
    expect_sig("R4", "late strobe busy", 0, 8'h8);
    busWrite(2'd1, 8'h00);
    doRead(6'd5);
    expect_sig("R4", "byte unchanged", 4, 8'h00);
    waitIdle();
    while (cpuStall) @(negedge clk);

    // R4/R5/R6 accepted on last armed cycle
    busWrite(2'd1, 8'hA5);
    busWrite(2'd2, 8'h0C);
    idle(3);
    busWrite(2'd2, 8'h0A);
    expect_sig("R4", "busy set, arm cleared", 0, 8'hA);
    expect_sig("R8", "irq masked", 2, 0);
    nBusy = 0; nStall = 0;
    while (ctrlOut[1]) begin
      nBusy++;
      if (cpuStall) nStall++;
      @(negedge clk);
    end
    expect_sig("R5", "busy cycles", -1, WR_CYC, nBusy);
    expect_sig("R6", "write stall cycles", -1, 2, nStall);
    expect_sig("R8", "irq back", 2, 1);

    // R7 read back
    busWrite(2'd1, 8'h00);
    doRead(6'd5);
    expect_sig("R7", "read data", 4, 8'hA5);
    expect_sig("R7", "read bit", 0, 8'h9);
    nRdStall = 0;
    while (cpuStall) begin nRdStall++; @(negedge clk); end
    expect_sig("R7", "read stall cycles", -1, 4, nRdStall);
    expect_sig("R7", "read bit cleared", 0, 8'h8);

    // R9/R10 corruption and read during busy
    busWrite(2'd0, 8'h07);
    busWrite(2'd1, 8'h3C);
    busWrite(2'd2, 8'h0C);
    busWrite(2'd2, 8'h0A);
    idle(3);
    busWrite(2'd1, 8'h55);
    expect_sig("R9", "fail flag", 3, 1);
    busWrite(2'd2, 8'h09);
    expect_sig("R10", "data kept", 4, 8'h55);
    expect_sig("R10", "read bit clear", 0, 8'hA);
    waitIdle();
    idle(1);
    expect_sig("R9", "fail held", 3, 1);
    doRead(6'd7);
    expect_sig("R9", "byte not stored", 4, 8'h00);
    while (cpuStall) @(negedge clk);

    // R9 next write clears the flag
    busWrite(2'd0, 8'h09);
    busWrite(2'd1, 8'h77);
    busWrite(2'd2, 8'h0C);
    busWrite(2'd2, 8'h0A);
    expect_sig("R9", "fail cleared", 3, 0);
    waitIdle();
    busWrite(2'd1, 8'h00);
    doRead(6'd9);
    expect_sig("R5", "byte stored", 4, 8'h77);

    // R8 global enable off
    globalIntEn = 1'b0;
    #1;
    expect_sig("R8", "irq gated", 2, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule